// File: doc/BRIEF.md
# Accelerator Event Profiler Counters

This block observes the activity of an accelerator made of four processing engines: load, save, convolution and miscellaneous. Each engine gives a one-cycle pulse when it starts an operation and another when it finishes one. The block counts each of the eight pulse kinds separately. It also keeps a cycle timestamp of processing time that stops at its maximum value, and it latches a flag byte describing the last cycle in which any event occurred. A counter of accelerator done pulses runs alongside these.

Software uses a simple 32-bit register port to work the block. The port is combinational on reads and takes effect on the clock edge for writes. A write-only enable bit starts a profiling session. Setting that bit from off to on wipes the previous results. Software can also write a 64-bit profiler buffer address. That address is not readable through the register port; it leaves the block on an output port so that other logic can use it.

Top module: `evprof`

## Requirements
- R1: After reset, every readable register returns zero, profiling is disabled and `prof_base` is zero.
- R2: Eight event counters sit at 0x098 + 4·i. Index i is 0..3 for the start pulses of load, save, convolution and misc, and 4..7 for their finish pulses in the same engine order. While profiling is enabled, each counter whose pulse is high at a clock edge increments by one. This holds even when several pulses are high in the same cycle.
- R3: The flag byte is read at 0x090. Bits 0..3 are the load, save, conv and misc starts, and bits 4..7 are the same engines' finishes. On an enabled cycle with at least one event, the byte takes exactly the set of bits that fired in that cycle. On cycles without events it keeps its value.
- R4: The timestamp at 0x094 counts clock edges while profiling is enabled. It stops at all ones (TS_W bits, default 32) rather than wrapping.
- R5: Bit 0 of a write to 0x084 sets the profiling enable. While the enable is 0, the event counters, the timestamp and the flag byte keep their values.
- R6: A write of 1 to 0x084 while the enable is 0 clears the event counters, the timestamp and the flag byte. It does not clear the done counter.
- R7: The done counter at 0x0C0 counts every `done_pulse`, whatever the enable state, and wraps at DONE_W bits (default 8).
- R8: Event counters wrap to zero after all ones (CNT_W bits, default 32).
- R9: A write to 0x088 sets bits 31:0 of `prof_base`, and a write to 0x08C sets bits 63:32.
- R10: Reads of 0x084, 0x088, 0x08C, unaligned addresses and unmapped addresses return zero. Writes to read-only offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_start | input | 4 | Start pulses: bit 0 load, 1 save, 2 conv, 3 misc |
| ev_finish | input | 4 | Finish pulses, same engine order |
| done_pulse | input | 1 | Accelerator done pulse |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| prof_base | output | 64 | Profiler buffer address written by software |

## Verification
The bench enables profiling and drives all 256 combinations of the eight event pulses, one combination per cycle. The done pulse follows bit 0 of each combination. After every cycle it reads all eight counters, the flag byte, the timestamp and the done counter. This separates a pulse routed to the wrong counter, a flag bit in the wrong position, and a flag that merges or drops events that occur together. A burst of events while profiling is disabled shows whether gating is missing on the counters or present on the done counter. Re-enabling after that burst tests the clear. Long runs of a single pulse and long idle stretches, on a small-width build, reach counter wrap and timestamp saturation.

// File: rtl/evprof.sv
module evprof #(
  parameter int CNT_W  = 32,
  parameter int TS_W   = 32,
  parameter int DONE_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  ev_start,
  input  logic [3:0]  ev_finish,
  input  logic        done_pulse,
  input  logic [7:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic [63:0] prof_base
);
  localparam int NEV = 8;

  logic              en;
  logic [NEV-1:0]    flag;
  logic [TS_W-1:0]   ts;
  logic [DONE_W-1:0] done_cnt;
  logic [CNT_W-1:0]  cnt [NEV];

  wire [NEV-1:0] ev      = {ev_finish, ev_start};
  wire           en_wr   = reg_wr && (reg_addr == 8'h84);
  wire           en_rise = en_wr && reg_wdata[0] && !en;
  wire           ts_full = &ts;

  always_ff @(posedge clk) begin
    if (!rst_n)     en <= 1'b0;
    else if (en_wr) en <= reg_wdata[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || en_rise)  ts <= '0;
    else if (en && !ts_full) ts <= ts + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || en_rise) flag <= '0;
    else if (en && |ev)    flag <= ev;
  end

  for (genvar i = 0; i < NEV; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n || en_rise) cnt[i] <= '0;
      else if (en && ev[i])  cnt[i] <= cnt[i] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          done_cnt <= '0;
    else if (done_pulse) done_cnt <= done_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prof_base <= '0;
    else if (reg_wr && reg_addr == 8'h88) prof_base[31:0]  <= reg_wdata;
    else if (reg_wr && reg_addr == 8'h8C) prof_base[63:32] <= reg_wdata;
  end

  wire [5:0] word = reg_addr[7:2];
  wire [2:0] idx  = 3'(word - 6'd38);
  wire       in_cnt = (reg_addr >= 8'h98) && (reg_addr <= 8'hB4) && (reg_addr[1:0] == 2'b00);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      8'h90:   reg_rdata = 32'(flag);
      8'h94:   reg_rdata = 32'(ts);
      8'hC0:   reg_rdata = 32'(done_cnt);
      default: if (in_cnt) reg_rdata = 32'(cnt[idx]);
    endcase
  end

  assert_ts_saturate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ts_full && !en_rise) |=> ts_full);
  assert_frozen_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !en_rise) |=> ($stable(ts) && $stable(flag) && $stable(cnt[0])));
  assert_clear_on_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> (ts == '0 && flag == '0 && en));
  assert_flag_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && |ev && !en_rise) |=> (flag == $past(ev)));
  assert_done_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (done_cnt == $past(done_cnt) + DONE_W'($past(done_pulse))));
  assert_flag_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|ev) && !en_rise) |=> $stable(flag));
endmodule

// File: tb/evprof_test.sv
`timescale 1ns/1ps
module evprof_test;
  localparam int CW = 8, TW = 10, DW = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [3:0]  ev_start = '0, ev_finish = '0;
  logic        done_pulse = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] prof_base;

  evprof #(.CNT_W(CW), .TS_W(TW), .DONE_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_finish(ev_finish),
    .done_pulse(done_pulse), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .prof_base(prof_base));

  always #4 clk = ~clk;

  int n_run = 0, n_fail = 0;
  logic          m_en;
  logic [CW-1:0] m_cnt [8];
  logic [TW-1:0] m_ts;
  logic [7:0]    m_flag;
  logic [DW-1:0] m_done;
  logic [63:0]   m_base;

  always @(posedge clk) begin
    logic [7:0] e;
    e = {ev_finish, ev_start};
    if (!rst_n) begin
      m_en = 0; m_ts = '0; m_flag = '0; m_done = '0; m_base = '0;
      for (int i = 0; i < 8; i++) m_cnt[i] = '0;
    end else begin
      if (done_pulse) m_done = m_done + 1'b1;
      if (m_en) begin
        for (int i = 0; i < 8; i++) if (e[i]) m_cnt[i] = m_cnt[i] + 1'b1;
        if (e != 0) m_flag = e;
        if (m_ts != '1) m_ts = m_ts + 1'b1;
      end
      if (reg_wr && reg_addr == 8'h84) begin
        if (reg_wdata[0] && !m_en) begin
          m_ts = '0; m_flag = '0;
          for (int i = 0; i < 8; i++) m_cnt[i] = '0;
        end
        m_en = reg_wdata[0];
      end
      if (reg_wr && reg_addr == 8'h88) m_base[31:0] = reg_wdata;
      if (reg_wr && reg_addr == 8'h8C) m_base[63:32] = reg_wdata;
    end
  end

  task automatic chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #0.1;
    n_run++;
    if (reg_rdata !== exp) begin
      n_fail++;
      $display("FAIL %s addr %h got %h expected %h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic chk_all();
    for (int i = 0; i < 8; i++) chk(8'h98 + 8'(4 * i), 32'(m_cnt[i]), "R2");
    chk(8'h90, 32'(m_flag), "R3");
    chk(8'h94, 32'(m_ts), "R4");
    chk(8'hC0, 32'(m_done), "R7");
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] s, input logic [3:0] f, input logic d);
    @(negedge clk); ev_start = s; ev_finish = f; done_pulse = d;
    @(negedge clk); ev_start = '0; ev_finish = '0; done_pulse = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all();  // R1
    chk(8'h90, 32'h0, "R1");
    n_run++;
    if (prof_base !== 64'h0) begin
      n_fail++; $display("FAIL R1 prof_base got %h expected 0", prof_base);
    end

    wr_reg(8'h84, 32'h1);  // R5 enable
    for (int v = 0; v < 256; v++) begin
      pulse(v[3:0], v[7:4], v[0]);
      chk_all();
    end
    @(negedge clk);
    chk(8'h90, 32'(m_flag), "R3");

    wr_reg(8'h84, 32'h0);
    pulse(4'hF, 4'hF, 1'b1);
    chk_all();  // R5 frozen, R7 counts while off
    chk(8'h98, 32'(m_cnt[0]), "R5");

    wr_reg(8'h98, 32'h55);
    wr_reg(8'h94, 32'h3);
    wr_reg(8'hC0, 32'h7);
    chk_all();  // R10 writes to read-only ignored
    chk(8'h98, 32'(m_cnt[0]), "R10");
    chk(8'h84, 32'h0, "R10");
    chk(8'h88, 32'h0, "R10");
    chk(8'h8C, 32'h0, "R10");
    chk(8'hC4, 32'h0, "R10");
    chk(8'h99, 32'h0, "R10");
    chk(8'h7C, 32'h0, "R10");

    wr_reg(8'h88, 32'hDEADBEEF);
    wr_reg(8'h8C, 32'h01234567);
    n_run++;
    if (prof_base !== 64'h01234567_DEADBEEF || prof_base !== m_base) begin
      n_fail++; $display("FAIL R9 prof_base got %h expected %h", prof_base, 64'h01234567_DEADBEEF);
    end
    chk(8'h88, 32'h0, "R9");

    wr_reg(8'h84, 32'h1);
    chk_all();  // R6 cleared, done kept
    chk(8'hC0, 32'(m_done), "R6");

    for (int k = 0; k < 300; k++) pulse(4'h1, 4'h8, 1'b1);
    chk_all();  // R8 wrap, R7 wrap
    chk(8'h98, 32'(m_cnt[0]), "R8");

    repeat (1100) @(negedge clk);
    chk(8'h94, 32'(m_ts), "R4");
    chk(8'h94, 32'h3FF, "R4");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule